// File: doc/BRIEF.md
# Reservation Tracker for Load-Reserved / Store-Conditional

This block sits in front of a small shared word memory used by several processing elements. Each element owns one reservation slot. The slot holds a valid bit and a full word address. A load-reserved fills the slot and returns the memory word. A later store-conditional from the same element writes only if the slot is still valid and holds the same address. On success it returns 1; on failure it returns 0 and leaves memory unchanged.

Any store that commits clears matching slots held by the other elements, in the way a snooping invalidation would. This covers both a plain store and a successful conditional one. A context-switch strobe clears the slot of its own element. A fixed-priority arbiter takes one access per cycle, so each access sees the effects of every earlier access. A load-reserved never locks anything. Only a committed store disturbs other elements.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset every memory word reads as zero, no element holds a reservation, and no response is valid.
- R2: When several elements request in one cycle, exactly the lowest-indexed requester is granted in that cycle. `grant` is combinational, and a non-requester is never granted.
- R3: A load-reserved (op code 2'b10) returns the addressed word and sets the issuer's reservation to that full address.
- R4: A plain load (op code 2'b00) returns the addressed word and changes no reservation.
- R5: A store-conditional (op code 2'b11) whose issuer holds a valid reservation for the same full address writes the word and returns 1 in bit 0, with all other bits zero.
- R6: A store-conditional without a valid matching reservation returns 0 and leaves memory unchanged. This includes a reservation held for a different address.
- R7: A committed store clears the reservation of every other element that holds that address. This applies to a plain store (op code 2'b01, which returns 0) and to a successful store-conditional. The issuer's own reservation and reservations for other addresses are kept.
- R8: A store-conditional always clears its issuer's reservation, whether it succeeds or fails.
- R9: A context-switch strobe on an element clears that element's reservation at the end of the cycle. If it arrives in the same cycle as that element's load-reserved, no reservation is left. An access granted in the same cycle is still judged on the state from before the strobe.
- R10: The response to a granted access is valid exactly one cycle after the grant. `resp_valid` is one-hot on the granted element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_PE | Access request per element, held until granted |
| req_op | input | 2*N_PE | Op code per element: 00 load, 01 store, 10 load-reserved, 11 store-conditional |
| req_addr | input | ADDR_W*N_PE | Word address per element |
| req_wdata | input | DATA_W*N_PE | Store data per element |
| ctx_switch | input | N_PE | Context-switch strobe per element |
| grant | output | N_PE | One-hot grant for this cycle |
| resp_valid | output | N_PE | Response valid per element, one cycle after grant |
| resp_data | output | DATA_W | Read data, or success flag in bit 0 for store-conditional |

## Verification
The bench uses the default build: four elements, 16 words of 32 bits. The random phase narrows addresses to a handful of words plus the top address. Reservations from different elements therefore collide often. A store-conditional then races against plain stores, other store-conditionals and context switches, all of which are predicted by an arithmetic model in the bench. Directed sequences cover the remaining cases:
- every word read after reset;
- a two-element race on one address;
- a near-miss address;
- a context switch in the same cycle as a load-reserved;
- a three-way request for the arbiter.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_LR    = 2'b10,
      OP_SC    = 2'b11
   } lrsc_op_e;
endpackage

// File: rtl/lrsc_arbiter.sv
module lrsc_arbiter #(
   parameter int N_PE = 4
) (
   input  logic [N_PE-1:0] req,
   output logic [N_PE-1:0] gnt
);
   // isolate the lowest set bit: lowest index wins
   assign gnt = req & (~req + N_PE'(1));
endmodule

// File: rtl/lrsc_link_bank.sv
module lrsc_link_bank
   import lrsc_pkg::*;
#(
   parameter int N_PE   = 4,
   parameter int ADDR_W = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [N_PE-1:0]        gnt,
   input  lrsc_op_e               op,
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   commit,
   input  logic [N_PE-1:0]        ctx_switch,
   output logic [N_PE-1:0]        lr_valid,
   output logic [N_PE-1:0]        hit
);
   logic [ADDR_W-1:0] lr_addr [N_PE];

   for (genvar i = 0; i < N_PE; i++) begin : g_slot
      assign hit[i] = lr_valid[i] && (lr_addr[i] == addr);

      always_ff @(posedge clk) begin
         if (rst) begin
            lr_valid[i] <= 1'b0;
            lr_addr[i]  <= '0;
         end else begin
            if (gnt[i] && op == OP_LR) begin
               lr_valid[i] <= 1'b1;
               lr_addr[i]  <= addr;
            end else if (gnt[i] && op == OP_SC) begin
               lr_valid[i] <= 1'b0;
            end else if (commit && !gnt[i] && hit[i]) begin
               lr_valid[i] <= 1'b0;   // snoop-style invalidation
            end
            if (ctx_switch[i]) lr_valid[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lrsc_word_store.sv
module lrsc_word_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] mem [DEPTH];

   assign rdata = mem[addr];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
   import lrsc_pkg::*;
#(
   parameter int N_PE   = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [N_PE-1:0]          req_valid,
   input  logic [2*N_PE-1:0]        req_op,
   input  logic [ADDR_W*N_PE-1:0]   req_addr,
   input  logic [DATA_W*N_PE-1:0]   req_wdata,
   input  logic [N_PE-1:0]          ctx_switch,
   output logic [N_PE-1:0]          grant,
   output logic [N_PE-1:0]          resp_valid,
   output logic [DATA_W-1:0]        resp_data
);
   if (N_PE < 1 || N_PE > 64) begin : g_bad_npe
      $error("lrsc_monitor: N_PE out of range");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
      $error("lrsc_monitor: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("lrsc_monitor: DATA_W must be positive");
   end

   lrsc_op_e          sel_op;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_wdata;
   logic              any_gnt;
   logic              sc_ok;
   logic              commit;
   logic [N_PE-1:0]   lr_valid;
   logic [N_PE-1:0]   hit;
   logic [DATA_W-1:0] rdata;

   lrsc_arbiter #(.N_PE(N_PE)) u_arb (
      .req (req_valid),
      .gnt (grant)
   );

   always_comb begin
      sel_op    = OP_LOAD;
      sel_addr  = '0;
      sel_wdata = '0;
      for (int i = 0; i < N_PE; i++) begin
         if (grant[i]) begin
            sel_op    = lrsc_op_e'(req_op[2*i +: 2]);
            sel_addr  = req_addr[ADDR_W*i +: ADDR_W];
            sel_wdata = req_wdata[DATA_W*i +: DATA_W];
         end
      end
   end

   assign any_gnt = |grant;
   assign sc_ok   = any_gnt && (sel_op == OP_SC) && (|(grant & hit));
   assign commit  = any_gnt && ((sel_op == OP_STORE) || sc_ok);

   lrsc_link_bank #(.N_PE(N_PE), .ADDR_W(ADDR_W)) u_links (
      .clk        (clk),
      .rst        (rst),
      .gnt        (grant),
      .op         (sel_op),
      .addr       (sel_addr),
      .commit     (commit),
      .ctx_switch (ctx_switch),
      .lr_valid   (lr_valid),
      .hit        (hit)
   );

   lrsc_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk   (clk),
      .rst   (rst),
      .addr  (sel_addr),
      .we    (commit),
      .wdata (sel_wdata),
      .rdata (rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         resp_valid <= '0;
         resp_data  <= '0;
      end else begin
         resp_valid <= grant;
         unique case (sel_op)
            OP_SC:    resp_data <= DATA_W'(sc_ok);
            OP_STORE: resp_data <= '0;
            default:  resp_data <= rdata;
         endcase
      end
   end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
   parameter int N_PE = 4
) (
   input logic            clk,
   input logic            rst,
   input logic [N_PE-1:0] req_valid,
   input logic [N_PE-1:0] grant,
   input logic [N_PE-1:0] resp_valid,
   input logic [N_PE-1:0] ctx_switch,
   input logic [N_PE-1:0] lr_valid,
   input logic [1:0]      sel_op
);
   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));

   assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
      (grant & ~req_valid) == '0);

   assert_resp_follows_grant_R10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> resp_valid == $past(grant));

   assert_sc_drops_own_R8: assert property (@(posedge clk) disable iff (rst)
      (|grant && sel_op == 2'b11) |=> (lr_valid & $past(grant)) == '0);

   assert_ctx_clears_R9: assert property (@(posedge clk) disable iff (rst)
      (|ctx_switch) |=> (lr_valid & $past(ctx_switch)) == '0);

   assert_lr_sets_R3: assert property (@(posedge clk) disable iff (rst)
      (|grant && sel_op == 2'b10 && (grant & ctx_switch) == '0)
         |=> (lr_valid & $past(grant)) == $past(grant));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.N_PE(N_PE)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .grant      (grant),
   .resp_valid (resp_valid),
   .ctx_switch (ctx_switch),
   .lr_valid   (lr_valid),
   .sel_op     (sel_op)
);

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
   localparam int N  = 4;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst;
   logic [N-1:0]    req_valid;
   logic [2*N-1:0]  req_op;
   logic [AW*N-1:0] req_addr;
   logic [DW*N-1:0] req_wdata;
   logic [N-1:0]    ctx_switch;
   logic [N-1:0]    grant;
   logic [N-1:0]    resp_valid;
   logic [DW-1:0]   resp_data;

   int tests = 0;
   int fails = 0;

   logic [DW-1:0] m_mem [DEPTH];
   logic          m_rv  [N];
   logic [AW-1:0] m_ra  [N];
   logic [31:0]   seed = 32'h1234_5678;

   always #4 clk = ~clk;   // 125 MHz

   lrsc_monitor #(.N_PE(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .ctx_switch(ctx_switch),
      .grant(grant), .resp_valid(resp_valid), .resp_data(resp_data)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   // reference model: evaluate on pre-state, then apply updates
   function automatic logic [DW-1:0] model(input int pe, input logic [1:0] op,
                                           input logic [AW-1:0] a, input logic [DW-1:0] wd,
                                           input logic [N-1:0] ctx);
      logic [DW-1:0] r;
      logic ok;
      ok = m_rv[pe] && (m_ra[pe] == a);
      r  = '0;
      case (op)
         2'b00: r = m_mem[a];
         2'b10: begin r = m_mem[a]; m_rv[pe] = 1'b1; m_ra[pe] = a; end
         2'b01: begin
            m_mem[a] = wd;
            for (int j = 0; j < N; j++) if (j != pe && m_rv[j] && m_ra[j] == a) m_rv[j] = 1'b0;
         end
         default: begin
            r = DW'(ok);
            m_rv[pe] = 1'b0;
            if (ok) begin
               m_mem[a] = wd;
               for (int j = 0; j < N; j++) if (j != pe && m_rv[j] && m_ra[j] == a) m_rv[j] = 1'b0;
            end
         end
      endcase
      for (int j = 0; j < N; j++) if (ctx[j]) m_rv[j] = 1'b0;
      return r;
   endfunction

   task automatic access(input string tag, input int pe, input logic [1:0] op,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [N-1:0] ctx);
      logic [DW-1:0] exp;
      @(negedge clk);
      req_valid = N'(1) << pe;
      req_op[2*pe +: 2]     = op;
      req_addr[AW*pe +: AW] = a;
      req_wdata[DW*pe +: DW] = wd;
      ctx_switch = ctx;
      exp = model(pe, op, a, wd, ctx);
      #1 check({tag, " R2 grant"}, DW'(grant), DW'(N'(1) << pe));
      @(negedge clk);
      req_valid  = '0;
      ctx_switch = '0;
      check({tag, " R10 resp_valid"}, DW'(resp_valid), DW'(N'(1) << pe));
      check(tag, resp_data, exp);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      rst = 1'b1;
      req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0; ctx_switch = '0;
      for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
      for (int j = 0; j < N; j++) begin m_rv[j] = 1'b0; m_ra[j] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check("R1 resp_valid after reset", DW'(resp_valid), '0);

      // R1: all words zero, no reservations
      for (int k = 0; k < DEPTH; k++) access("R1 reset word / R4 load", 0, 2'b00, AW'(k), '0, '0);
      for (int j = 0; j < N; j++) access("R1 no reservation / R6 sc fails", j, 2'b11, AW'(j), 32'hDEAD, '0);
      access("R6 no write after failed sc", 1, 2'b00, 4'd1, '0, '0);

      // R5 / R7: race on one address
      access("R3 lr pe0", 0, 2'b10, 4'd5, '0, '0);
      access("R3 lr pe1", 1, 2'b10, 4'd5, '0, '0);
      access("R5 sc pe1 succeeds", 1, 2'b11, 4'd5, 32'hAAAA_0001, '0);
      access("R7 sc pe0 fails after invalidation", 0, 2'b11, 4'd5, 32'hBBBB_0002, '0);
      access("R3 lr returns written word", 2, 2'b10, 4'd5, '0, '0);

      // R7: own plain store keeps reservation; other address untouched
      access("R3 lr pe2", 2, 2'b10, 4'd6, '0, '0);
      access("R7 store own addr", 2, 2'b01, 4'd6, 32'h0000_0066, '0);
      access("R3 lr pe3", 3, 2'b10, 4'd7, '0, '0);
      access("R7 store other addr", 0, 2'b01, 4'd8, 32'h0000_0088, '0);
      access("R7 pe2 sc keeps own", 2, 2'b11, 4'd6, 32'h0000_0067, '0);
      access("R7 pe3 sc unaffected", 3, 2'b11, 4'd7, 32'h0000_0077, '0);

      // R6 / R8: address mismatch, then retry fails
      access("R3 lr pe0 addr2", 0, 2'b10, 4'd2, '0, '0);
      access("R6 sc near-miss address", 0, 2'b11, 4'd3, 32'h3333, '0);
      access("R8 retry after failed sc", 0, 2'b11, 4'd2, 32'h2222, '0);

      // R9: context switch cases
      access("R3 lr pe1", 1, 2'b10, 4'd9, '0, '0);
      access("R9 ctx strobe", 0, 2'b00, 4'd9, '0, 4'b0010);
      access("R9 sc after ctx fails", 1, 2'b11, 4'd9, 32'h9999, '0);
      access("R9 lr with ctx same cycle", 1, 2'b10, 4'd9, '0, 4'b0010);
      access("R9 sc after cancelled lr", 1, 2'b11, 4'd9, 32'h9999, '0);
      access("R3 lr pe3", 3, 2'b10, 4'd10, '0, '0);
      access("R9 sc same cycle as ctx", 3, 2'b11, 4'd10, 32'hAAAA, 4'b1000);

      // R2: three simultaneous load-reserved requests
      @(negedge clk);
      req_valid = 4'b1110;
      for (int j = 1; j < N; j++) begin
         req_op[2*j +: 2] = 2'b10;
         req_addr[AW*j +: AW] = AW'(12 + j);
      end
      for (int j = 1; j < N; j++) begin
         logic [DW-1:0] e;
         #1 check("R2 priority grant", DW'(grant), DW'(N'(1) << j));
         e = model(j, 2'b10, AW'(12 + j), '0, '0);
         @(negedge clk);
         req_valid[j] = 1'b0;
         check("R10 resp to priority winner", DW'(resp_valid), DW'(N'(1) << j));
         check("R3 data to priority winner", resp_data, e);
      end
      for (int j = 1; j < N; j++) access("R5 sc after contention", j, 2'b11, AW'(12 + j), DW'(j), '0);

      // random sweep over a few colliding addresses
      for (int t = 0; t < 3000; t++) begin
         logic [31:0] r;
         logic [AW-1:0] a;
         logic [N-1:0] c;
         r = rnd();
         a = (r[9:7] == 3'd7) ? AW'(DEPTH - 1) : AW'(r[8:7]);
         c = (r[12:10] == 3'd0) ? (N'(1) << r[14:13]) : '0;
         access("R3-R9 sweep", int'(r[3:2]), r[5:4], a, rnd(), c);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule